// File: doc/BRIEF.md
# Non-Overlapping Synchronous Gate Sequencer

This block turns one PWM request into two complementary gate commands, one for the high-side switch and one for the low-side switch of a synchronous buck power stage. Before either gate turns on, the block waits until the opposite switch reports through its gate-off feedback flag that it is fully off. The flag must then stay high for a minimum number of clock cycles. This dead interval adapts to the real turn-off time of the switch and is never shorter than the programmed minimum.

A cycle-start strobe arms the high-side gate for one pulse. An over-current flag ends that pulse and keeps the high side blanked until the next strobe. An over-voltage force from the power sequencer keeps the high side off and the low side on. The low side still obeys the dead-time rule when it turns on. If a feedback flag never confirms off, the block parks both gates low and raises a fault. The fault stays until the enable is removed.

Top module: `gdrv_nonoverlap`

## Requirements
- R1: While reset is active, and in the cycle after `en` is sampled low, `hs_gate`, `ls_gate` and `drv_fault` are all low.
- R2: `hs_gate` and `ls_gate` are never high in the same cycle.
- R3: `hs_gate` rises only after both gates have been low and `ls_off_fb` has been sampled high for DEAD_CYC consecutive cycles. A low sample restarts the count.
- R4: `ls_gate` rises only after both gates have been low and `hs_off_fb` has been sampled high for DEAD_CYC consecutive cycles.
- R5: A high-side pulse needs a `cyc_start` strobe followed by an active `pwm_req`. The strobe takes effect one cycle after it is sampled. After a pulse ends, the high side stays off until the next strobe, even if `pwm_req` returns high.
- R6: When `oc_flag` is sampled high, the high side is off in the next cycle. It stays blanked until a later `cyc_start`, even after `oc_flag` clears.
- R7: When `ovp_force` is sampled high, `hs_gate` is low in the next cycle, and `ls_gate` turns on through the R4 dead interval. This holds whatever the state of `pwm_req`, the strobe or the current limit.
- R8: If the awaited feedback flag stays low for TMO_CYC sampled cycles in a dead interval, both gates go low and `drv_fault` rises. It then stays high, with both gates low, until `en` is sampled low.
- R9: While enabled, not in fault, and the high side is not requested, the low side is driven on, once the R4 dead interval has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable from the sequencer; low forces both gates off and clears a fault |
| ovp_force | input | 1 | Over-voltage override: high side off, low side on |
| pwm_req | input | 1 | PWM request, high asks for the high-side switch |
| cyc_start | input | 1 | One-cycle strobe at the start of each switching cycle |
| oc_flag | input | 1 | Over-current detected on the high-side switch |
| hs_off_fb | input | 1 | High-side switch confirmed fully off |
| ls_off_fb | input | 1 | Low-side switch confirmed fully off |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| drv_fault | output | 1 | Feedback timeout fault |

## Verification
The stimulus table takes the gates through full switching periods. Some periods end by a falling `pwm_req`, some by `oc_flag` and some by `ovp_force`. This separates the three ways the high side can be cut and shows which of them leave it blanked until a new strobe. Each dead interval is tried with the awaited feedback flag held low first and then raised, so an early turn-on and a dead count that is too short or too long show up as a gate edge in the wrong cycle. A directed run holds a feedback flag low until the timeout, then raises it to show that the fault latches, and then drops `en` to show that the fault clears.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  typedef enum logic [2:0] {
    GS_IDLE  = 3'd0,
    GS_HI    = 3'd1,
    GS_LO    = 3'd2,
    GS_TO_HI = 3'd3,
    GS_TO_LO = 3'd4,
    GS_FAULT = 3'd5
  } gstate_e;

endpackage

// File: rtl/gdrv_hs_permit.sv
module gdrv_hs_permit (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_start,
  input  logic oc_flag,
  input  logic pulse_end,
  output logic permit
);

  logic permit_q;
  logic permit_d;
  logic permit_ce;

  // Armed by the strobe. Disarmed by over-current, by the end of the pulse or by disable.
  always_comb begin
    if (!en) begin
      permit_d = 1'b0;
    end else begin
      permit_d = (cyc_start & ~oc_flag) | (permit_q & ~oc_flag & ~pulse_end);
    end
    permit_ce = (permit_d != permit_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      permit_q <= 1'b0;
    end else if (permit_ce) begin
      permit_q <= permit_d;
    end
  end

  assign permit = permit_q;

  p_oc_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> !permit_q);

  p_arm_by_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(permit_q) |-> $past(cyc_start));

endmodule

// File: rtl/gdrv_dead_timer.sv
module gdrv_dead_timer #(
  parameter int DEAD_CYC = 2,
  parameter int TMO_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fb_ok,
  output logic dead_done,
  output logic tmo_hit
);

  localparam int DW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_CYC - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);

  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          cnt_ce;

  assign dead_done = fb_ok & (dcnt_q == DEAD_LAST);
  assign tmo_hit   = ~fb_ok & (tcnt_q == TMO_LAST);

  always_comb begin
    dcnt_d = dcnt_q;
    tcnt_d = tcnt_q;
    if (clr) begin
      dcnt_d = '0;
      tcnt_d = '0;
    end else if (fb_ok) begin
      if (dcnt_q != DEAD_LAST) begin
        dcnt_d = dcnt_q + 1'b1;
      end
    end else begin
      dcnt_d = '0;
      if (tcnt_q != TMO_LAST) begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
    cnt_ce = (dcnt_d != dcnt_q) || (tcnt_d != tcnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      tcnt_q <= '0;
    end else if (cnt_ce) begin
      dcnt_q <= dcnt_d;
      tcnt_q <= tcnt_d;
    end
  end

  p_dead_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= DEAD_LAST);

  p_dead_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fb_ok || clr) |=> (dcnt_q == '0));

endmodule

// File: rtl/gdrv_nonoverlap.sv
module gdrv_nonoverlap #(
  parameter int DEAD_CYC = 2,
  parameter int TMO_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ovp_force,
  input  logic pwm_req,
  input  logic cyc_start,
  input  logic oc_flag,
  input  logic hs_off_fb,
  input  logic ls_off_fb,
  output logic hs_gate,
  output logic ls_gate,
  output logic drv_fault
);

  import gdrv_pkg::*;

  gstate_e state_q, state_d;
  logic    state_ce;
  logic    permit;
  logic    want_hs;
  logic    waiting;
  logic    fb_ok;
  logic    dead_done;
  logic    tmo_hit;
  logic    timer_clr;
  logic    pulse_end;

  // The over-voltage force outranks the request, the strobe permit and the current limit.
  assign want_hs = en & ~ovp_force & pwm_req & permit & ~oc_flag;
  assign waiting = (state_q == GS_TO_HI) || (state_q == GS_TO_LO);
  assign fb_ok   = (state_q == GS_TO_HI) ? ls_off_fb : hs_off_fb;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = GS_IDLE;
    end else begin
      unique case (state_q)
        GS_IDLE:  state_d = want_hs ? GS_TO_HI : GS_TO_LO;
        GS_HI:    if (!want_hs) state_d = GS_TO_LO;
        GS_LO:    if (want_hs)  state_d = GS_TO_HI;
        GS_TO_HI: begin
          if (!want_hs)       state_d = GS_TO_LO;
          else if (tmo_hit)   state_d = GS_FAULT;
          else if (dead_done) state_d = GS_HI;
        end
        GS_TO_LO: begin
          if (want_hs)        state_d = GS_TO_HI;
          else if (tmo_hit)   state_d = GS_FAULT;
          else if (dead_done) state_d = GS_LO;
        end
        GS_FAULT: state_d = GS_FAULT;
        default:  state_d = GS_IDLE;
      endcase
    end
    state_ce = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
    end else if (state_ce) begin
      state_q <= state_d;
    end
  end

  assign timer_clr = state_ce | ~waiting;
  assign pulse_end = (state_q == GS_HI) && (state_d != GS_HI);

  gdrv_dead_timer #(
    .DEAD_CYC (DEAD_CYC),
    .TMO_CYC  (TMO_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (timer_clr),
    .fb_ok     (fb_ok),
    .dead_done (dead_done),
    .tmo_hit   (tmo_hit)
  );

  gdrv_hs_permit u_permit (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cyc_start (cyc_start),
    .oc_flag   (oc_flag),
    .pulse_end (pulse_end),
    .permit    (permit)
  );

  assign hs_gate   = (state_q == GS_HI);
  assign ls_gate   = (state_q == GS_LO);
  assign drv_fault = (state_q == GS_FAULT);

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  p_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_gate && !ls_gate && !drv_fault));

  p_hs_after_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> ($past(ls_off_fb) && $past(!ls_gate)));

  p_ls_after_fb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> ($past(hs_off_fb) && $past(!hs_gate)));

  p_oc_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> !hs_gate);

  p_ovp_hs_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_force |=> !hs_gate);

  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_fault && en) |=> drv_fault);

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_fault |-> (!hs_gate && !ls_gate));

endmodule

// File: tb/tb_gdrv_nonoverlap.sv
module tb_gdrv_nonoverlap;

  localparam int DEAD = 2;
  localparam int TMO  = 16;
  localparam int NV   = 37;

  logic clk;
  logic rst_n;
  logic en, ovp_force, pwm_req, cyc_start, oc_flag, hs_off_fb, ls_off_fb;
  logic hs_gate, ls_gate, drv_fault;

  int n_chk;
  int n_fail;
  int n_ovl_chk;
  int n_ovl_fail;
  bit finished;

  gdrv_nonoverlap #(.DEAD_CYC(DEAD), .TMO_CYC(TMO)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ovp_force (ovp_force),
    .pwm_req   (pwm_req),
    .cyc_start (cyc_start),
    .oc_flag   (oc_flag),
    .hs_off_fb (hs_off_fb),
    .ls_off_fb (ls_off_fb),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate),
    .drv_fault (drv_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Row: {en, ovp, pwm, cyc, oc, hs_fb, ls_fb} {exp hs, exp ls, exp fault} {requirement}
  localparam logic [13:0] VEC [NV] = '{
    {7'b1000011, 3'b000, 4'd4},  // R4 idle -> dead interval
    {7'b1000011, 3'b000, 4'd4},  // R4 count 1
    {7'b1000011, 3'b010, 4'd9},  // R9 low side on
    {7'b1010010, 3'b010, 4'd5},  // R5 pwm without strobe
    {7'b1011010, 3'b010, 4'd5},  // R5 strobe, effective next cycle
    {7'b1010010, 3'b000, 4'd3},  // R3 enter dead interval
    {7'b1010010, 3'b000, 4'd3},  // R3 ls not yet off
    {7'b1010011, 3'b000, 4'd3},  // R3 count 1
    {7'b1010011, 3'b100, 4'd3},  // R3 high side on
    {7'b1010001, 3'b100, 4'd3},  // R3 hold
    {7'b1000001, 3'b000, 4'd9},  // R9 pwm falls
    {7'b1000011, 3'b000, 4'd4},  // R4 count 1
    {7'b1000011, 3'b010, 4'd9},  // R9 low side on
    {7'b1010010, 3'b010, 4'd5},  // R5 no rearm without strobe
    {7'b1011010, 3'b010, 4'd5},  // R5 strobe
    {7'b1010110, 3'b010, 4'd6},  // R6 oc kills permit
    {7'b1010010, 3'b010, 4'd6},  // R6 still blanked
    {7'b1011010, 3'b010, 4'd6},  // R6 new strobe
    {7'b1010010, 3'b000, 4'd3},  // R3 enter dead
    {7'b1010011, 3'b000, 4'd3},  // R3 count 1
    {7'b1010011, 3'b100, 4'd3},  // R3 high side on
    {7'b1010101, 3'b000, 4'd6},  // R6 oc mid pulse
    {7'b1010011, 3'b000, 4'd6},  // R6 oc cleared, still blanked
    {7'b1010011, 3'b010, 4'd6},  // R6 low side on
    {7'b1011010, 3'b010, 4'd5},  // R5 strobe
    {7'b1010010, 3'b000, 4'd3},  // R3 enter dead
    {7'b1010011, 3'b000, 4'd3},  // R3 count 1
    {7'b1010011, 3'b100, 4'd3},  // R3 high side on
    {7'b1110001, 3'b000, 4'd7},  // R7 ovp cuts high side
    {7'b1110011, 3'b000, 4'd7},  // R7 dead count
    {7'b1110011, 3'b010, 4'd7},  // R7 low side on
    {7'b1111010, 3'b010, 4'd7},  // R7 strobe ignored
    {7'b1110010, 3'b010, 4'd7},  // R7 pwm ignored
    {7'b1010010, 3'b000, 4'd3},  // R3 ovp gone
    {7'b1010011, 3'b000, 4'd3},  // R3 count 1
    {7'b1010011, 3'b100, 4'd3},  // R3 high side on
    {7'b0000011, 3'b000, 4'd1}   // R1 disable
  };

  task automatic check(input logic hs_e, input logic ls_e, input logic f_e, input int req);
    n_chk++;
    if (hs_gate !== hs_e || ls_gate !== ls_e || drv_fault !== f_e) begin
      n_fail++;
      $display("FAIL R%0d: hs/ls/fault = %b%b%b expected %b%b%b at %0t",
               req, hs_gate, ls_gate, drv_fault, hs_e, ls_e, f_e, $time);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    {en, ovp_force, pwm_req, cyc_start, oc_flag, hs_off_fb, ls_off_fb} = v;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  // R2: overlap checked on every clock
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      n_ovl_chk++;
      if (hs_gate === 1'b1 && ls_gate === 1'b1) begin
        n_ovl_fail++;
        $display("FAIL R2: hs/ls = 11 expected not both high at %0t", $time);
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", (n_chk + n_ovl_chk) - (n_fail + n_ovl_fail),
             n_chk + n_ovl_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected end before timeout");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; n_ovl_chk = 0; n_ovl_fail = 0; finished = 0;
    rst_n = 1'b0;
    drive(7'b1010011);
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, 1'b0, 1);  // R1 outputs low in reset
    drive(7'b0000011);
    rst_n = 1'b1;
    step();
    check(1'b0, 1'b0, 1'b0, 1);  // R1 idle while disabled

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13:7]);
      step();
      check(VEC[i][6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    end

    // R8: high-side feedback never confirms off
    drive(7'b1000001);
    step();
    check(1'b0, 1'b0, 1'b0, 8);
    repeat (TMO - 1) step();
    check(1'b0, 1'b0, 1'b0, 8);  // one sample short of the timeout
    step();
    check(1'b0, 1'b0, 1'b1, 8);  // timeout reached
    drive(7'b1010011);
    repeat (3) step();
    check(1'b0, 1'b0, 1'b1, 8);  // fault latched despite feedback
    drive(7'b0000011);
    step();
    check(1'b0, 1'b0, 1'b0, 1);  // R1 disable clears fault

    // R4: a feedback glitch restarts the dead count
    drive(7'b1000011);
    step();                        // enter dead interval
    step();                        // count 1
    drive(7'b1000001);
    step();
    check(1'b0, 1'b0, 1'b0, 4);  // glitch, count restarts
    drive(7'b1000011);
    step();
    check(1'b0, 1'b0, 1'b0, 4);  // count 1 again, still low
    step();
    check(1'b0, 1'b1, 1'b0, 4);  // low side on after full interval

    finished = 1;
    finish_run();
  end

endmodule